// File: doc/BRIEF.md
# Asynchronous Serial Port with Shared Bit-Rate Generator

This block is a full-duplex asynchronous serial port. Its transmit and receive paths run independently of each other. Both take their timing from one bit-rate generator, which is programmed by an 8-bit divisor and a speed select. Each frame on the line is NRZ with an idle-high line. A frame has one low start bit, then eight or nine data bits with the least significant bit first, then one high stop bit.

Words to send enter through a valid/ready stream into a one-word holding register. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the holding register is occupied, and the producer must then hold its word. Received words leave through a valid/ready stream fed by a small FIFO. Each word carries its framing-error flag. A word stays on `rx_data`/`rx_ferr` with `rx_valid` high until the consumer raises `rx_ready`. When the FIFO is full and a new frame completes, that frame is discarded and the overrun flag is raised. The receiver then stays halted until continuous receive is turned off and back on.

The receiver oversamples the line 16 times per bit. It opens a frame on a falling edge of the line. Each bit value is the majority of three samples taken around the middle of the bit.

Top module: `async_serial_port`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `tx_shift_empty` is 1, `rx_valid` is 0 and `rx_overrun` is 0.
- R2: With `cfg_fast`=1 one bit on `txd` lasts (`cfg_divisor`+1)×16 clock cycles.
- R3: With `cfg_fast`=0 one bit on `txd` lasts (`cfg_divisor`+1)×64 clock cycles.
- R4: A frame is a 0 start bit, the data bits with bit 0 first, then a 1 stop bit. A word sent on `tx_data` appears in this form on `txd`. A frame in this form on `rxd` is delivered on `rx_data`.
- R5: When the nine-bit select of a direction is 1, the frame carries nine data bits and bit 8 of the word is the last data bit. In eight-bit receive mode, `rx_data[8]` is 0.
- R6: `tx_ready` is 1 exactly when the holding register is empty. A second word is accepted while the first is shifting. `tx_shift_empty` falls when the start bit begins and rises only after the whole stop bit has been sent, so a single 8-bit frame keeps it low for 10 bit times.
- R7: Each received bit is the 2-of-3 majority of the line sampled at oversample ticks 7, 8 and 9 of 16. A disturbance shorter than one tick in mid-bit does not change the bit.
- R8: A low pulse on `rxd` whose mid-start-bit majority is 1 is discarded and delivers no word.
- R9: A stop bit sampled as 0 delivers the word with `rx_ferr`=1. The flag belongs to that word only.
- R10: A frame that completes while the FIFO (default two words) is full and not being read is discarded and sets `rx_overrun`. No further frame is received until `rx_continuous` is driven 0, which clears the flag, and then 1 again.
- R11: While `rx_valid` is 1 and `rx_ready` is 0, `rx_data` and `rx_ferr` hold their values. Words leave in arrival order.
- R12: While `tx_enable` is 0, an accepted word waits in the holding register and `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_divisor | input | 8 | Bit-rate divisor |
| cfg_fast | input | 1 | 1: 16 clocks per divisor step per bit, 0: 64 |
| cfg_tx_nine | input | 1 | Transmit nine data bits |
| cfg_rx_nine | input | 1 | Receive nine data bits |
| tx_enable | input | 1 | Allow frames to start on the line |
| rx_port_en | input | 1 | Receiver enable |
| rx_continuous | input | 1 | Continuous receive; driving 0 clears overrun |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | Word on `tx_data` is offered |
| tx_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial output line |
| tx_shift_empty | output | 1 | No frame in progress |
| rxd | input | 1 | Serial input line |
| rx_data | output | 9 | Received word |
| rx_ferr | output | 1 | Framing error of the word on `rx_data` |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_overrun | output | 1 | A frame was lost; receiver halted |

## Verification
`tx_ready` falls one clock after an accept. The start bit appears on the next oversample tick, within (`cfg_divisor`+1) clocks (×4 in slow mode). A received word shows on `rx_valid` two clocks after the tick that samples the middle of the stop bit. The transmit line is decoded at mid-bit instants counted from its falling edge. Run lengths of `txd` and `tx_shift_empty` are measured in whole clock counts and compared with the exact bit-time products. Received words are compared through a queue at the stream handshake rather than at a fixed cycle. Overrun and idle checks are taken only after the driver has held the stop bit for a full bit time.

// File: rtl/asp_pkg.sv
package asp_pkg;
  // payload width of one serial word (eight data bits plus optional ninth)
  localparam int WORD_W = 9;

  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_BUSY = 1'b1
  } line_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/asp_baud_gen.sv
module asp_baud_gen #(
  parameter int DIV_W    = 8,
  parameter int SLOW_MUL = 4   // power of two
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fast,
  output logic             tick
);
  localparam int MUL_W = $clog2(SLOW_MUL);
  localparam int CNT_W = DIV_W + MUL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // tick period: divisor+1 clocks, or SLOW_MUL times that in slow mode
  always_comb begin
    if (fast) limit = {{MUL_W{1'b0}}, divisor};
    else      limit = {divisor, {MUL_W{1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= limit) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              nine,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              shift_empty
);
  localparam int SUB_W = $clog2(OVS);
  localparam int FR_W  = WORD_W + 2;
  localparam int IDX_W = $clog2(FR_W);

  line_state_e       state_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] hold_q;
  logic [FR_W-1:0]   frame_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  stop_q;
  logic [SUB_W-1:0]  sub_q;
  logic              txd_q;

  logic            bit_end;
  logic            last_tick;
  logic            load;
  logic [FR_W-1:0] next_frame;

  assign bit_end    = tick && (state_q == LN_BUSY) && (sub_q == SUB_W'(OVS - 1));
  assign last_tick  = bit_end && (idx_q == stop_q);
  assign load       = tick && hold_full_q && enable && ((state_q == LN_IDLE) || last_tick);
  assign next_frame = {1'b1, (nine ? hold_q[WORD_W-1] : 1'b1), hold_q[WORD_W-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LN_IDLE;
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      frame_q     <= '1;
      idx_q       <= '0;
      stop_q      <= '0;
      sub_q       <= '0;
      txd_q       <= 1'b1;
    end else begin
      if (in_valid && !hold_full_q) begin
        hold_full_q <= 1'b1;
        hold_q      <= in_data;
      end else if (load) begin
        hold_full_q <= 1'b0;
      end

      if (load) begin
        state_q <= LN_BUSY;
        frame_q <= next_frame;
        idx_q   <= '0;
        sub_q   <= '0;
        stop_q  <= nine ? IDX_W'(FR_W - 1) : IDX_W'(FR_W - 2);
        txd_q   <= 1'b0;
      end else if (last_tick) begin
        state_q <= LN_IDLE;
        txd_q   <= 1'b1;
      end else if (bit_end) begin
        sub_q   <= '0;
        idx_q   <= idx_q + 1'b1;
        txd_q   <= frame_q[1];
        frame_q <= {1'b1, frame_q[FR_W-1:1]};
      end else if (tick && (state_q == LN_BUSY)) begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign in_ready    = !hold_full_q;
  assign txd         = txd_q;
  assign shift_empty = (state_q == LN_IDLE);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine,
  input  logic              run,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              ferr
);
  localparam int SUB_W = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int IDX_W = $clog2(WORD_W + 2);

  logic [1:0]        sync_q;
  logic              smp;
  logic              prev_q;
  line_state_e       state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  stop_q;
  logic              nine_q;
  logic [1:0]        votes_q;
  logic [WORD_W-1:0] data_q;
  logic              vote_now;

  assign smp      = sync_q[1];
  assign vote_now = vote3(votes_q[0], votes_q[1], smp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      state_q <= LN_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      stop_q  <= '0;
      nine_q  <= 1'b0;
      votes_q <= 2'b11;
      data_q  <= '0;
      done    <= 1'b0;
      word    <= '0;
      ferr    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      done   <= 1'b0;
      if (tick) begin
        if (state_q == LN_IDLE || !run) begin
          state_q <= LN_IDLE;
          prev_q  <= smp;
          if (state_q == LN_IDLE && run && prev_q && !smp) begin
            state_q <= LN_BUSY;
            sub_q   <= '0;
            idx_q   <= '0;
            nine_q  <= nine;
            stop_q  <= nine ? IDX_W'(WORD_W + 1) : IDX_W'(WORD_W);
          end
        end else begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == SUB_W'(MID - 1)) votes_q[0] <= smp;
          if (sub_q == SUB_W'(MID))     votes_q[1] <= smp;
          if (sub_q == SUB_W'(MID + 1)) begin
            if (idx_q == '0) begin
              if (vote_now) begin
                state_q <= LN_IDLE;
                prev_q  <= smp;
              end
            end else if (idx_q == stop_q) begin
              done    <= 1'b1;
              ferr    <= !vote_now;
              word    <= nine_q ? data_q : {1'b0, data_q[WORD_W-1:1]};
              state_q <= LN_IDLE;
              prev_q  <= smp;
            end else begin
              data_q <= {vote_now, data_q[WORD_W-1:1]};
            end
          end
          if (sub_q == SUB_W'(OVS - 1)) begin
            sub_q <= '0;
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/asp_fifo.sv
module asp_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic         full,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q;
  logic [PW-1:0] rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid = (cnt_q != '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem_q[rd_q];
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int OVS      = 16,
  parameter int SLOW_MUL = 4,
  parameter int RX_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_fast,
  input  logic             cfg_tx_nine,
  input  logic             cfg_rx_nine,
  input  logic             tx_enable,
  input  logic             rx_port_en,
  input  logic             rx_continuous,
  input  logic [8:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  output logic             tx_shift_empty,
  input  logic             rxd,
  output logic [8:0]       rx_data,
  output logic             rx_ferr,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_overrun
);
  logic              tick;
  logic              rx_done;
  logic [WORD_W-1:0] rx_word;
  logic              rx_word_ferr;
  logic              fifo_full;
  logic              pop;
  logic              push;
  logic              overrun_q;
  logic              rx_run;

  asp_baud_gen #(.DIV_W(DIV_W), .SLOW_MUL(SLOW_MUL)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(cfg_divisor), .fast(cfg_fast), .tick(tick)
  );

  asp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(tx_enable), .nine(cfg_tx_nine),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .txd(txd), .shift_empty(tx_shift_empty)
  );

  assign rx_run = rx_port_en && rx_continuous && !overrun_q;

  asp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(cfg_rx_nine), .run(rx_run),
    .done(rx_done), .word(rx_word), .ferr(rx_word_ferr)
  );

  assign pop  = rx_valid && rx_ready;
  assign push = rx_done && !(fifo_full && !pop);

  asp_fifo #(.W(WORD_W + 1), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din({rx_word_ferr, rx_word}),
    .pop(pop), .valid(rx_valid), .full(fifo_full), .dout({rx_ferr, rx_data})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               overrun_q <= 1'b0;
    else if (!rx_continuous)                  overrun_q <= 1'b0;
    else if (rx_done && fifo_full && !pop)    overrun_q <= 1'b1;
  end

  assign rx_overrun = overrun_q;
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_continuous,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       tx_shift_empty,
  input logic [8:0] rx_data,
  input logic       rx_ferr,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_overrun
);
  // R1: an idle transmitter keeps the line high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shift_empty |-> txd);

  // R4: a frame starts with a low start bit
  a_r4_start_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_shift_empty) |-> !txd);

  // R6: an accepted word occupies the holding register
  a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R11: a stalled output word holds still
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_ferr)));

  // R10: overrun stays until continuous receive is dropped
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && rx_continuous) |=> rx_overrun);
endmodule

bind async_serial_port asp_checker u_asp_checker (
  .clk(clk), .rst_n(rst_n), .rx_continuous(rx_continuous),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .tx_shift_empty(tx_shift_empty),
  .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_overrun(rx_overrun)
);

// File: tb/tb_async_serial_port.sv
`timescale 1ns/1ps
module tb_async_serial_port;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] cfg_divisor = 8'd3;
  logic       cfg_fast = 1'b1, cfg_tx_nine = 1'b0, cfg_rx_nine = 1'b0;
  logic       tx_enable = 1'b1, rx_port_en = 1'b1, rx_continuous = 1'b1;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, tx_shift_empty;
  logic       rxd = 1'b1;
  logic [8:0] rx_data;
  logic       rx_ferr, rx_valid;
  logic       rx_ready = 1'b1;
  logic       rx_overrun;

  async_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor), .cfg_fast(cfg_fast),
    .cfg_tx_nine(cfg_tx_nine), .cfg_rx_nine(cfg_rx_nine), .tx_enable(tx_enable),
    .rx_port_en(rx_port_en), .rx_continuous(rx_continuous),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .tx_shift_empty(tx_shift_empty), .rxd(rxd), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  int vecs = 0, errs = 0;
  int bitclk = 64;
  int cyc = 0;
  logic [8:0] txq[$];
  logic [9:0] rxq[$];
  string      rtag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // run-length trackers on txd and tx_shift_empty
  int fall_c = 0, last_low = 0, efall_c = 0, empty_low = 0;
  logic p_txd = 1'b1, p_emp = 1'b1;
  bit low_seen = 0;
  always @(negedge clk) begin
    if (p_txd === 1'b1 && txd === 1'b0) fall_c = cyc;
    if (p_txd === 1'b0 && txd === 1'b1) last_low = cyc - fall_c;
    if (p_emp === 1'b1 && tx_shift_empty === 1'b0) efall_c = cyc;
    if (p_emp === 1'b0 && tx_shift_empty === 1'b1) empty_low = cyc - efall_c;
    if (txd === 1'b0) low_seen = 1;
    p_txd = txd;
    p_emp = tx_shift_empty;
  end

  // transmit monitor: decode txd at mid-bit and compare with the scoreboard
  logic [8:0] mw, me;
  bit mn;
  initial begin
    forever begin
      @(negedge txd);
      mn = cfg_tx_nine;
      mw = '0;
      repeat (bitclk / 2) @(negedge clk);
      check("R4 tx start bit", txd, 0);
      for (int i = 0; i < (mn ? 9 : 8); i++) begin
        repeat (bitclk) @(negedge clk);
        mw[i] = txd;
      end
      repeat (bitclk) @(negedge clk);
      check("R4 tx stop bit", txd, 1);
      if (txq.size() == 0) begin
        check("R4 tx unexpected frame", mw, 9'h1ff);
      end else begin
        me = txq.pop_front();
        if (!mn) me[8] = 1'b0;
        check(mn ? "R5 tx nine-bit word" : "R4 tx word", mw, me);
      end
    end
  end

  // receive monitor: compare every handshake with the scoreboard
  logic [9:0] re;
  string rt;
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid === 1'b1 && rx_ready === 1'b1) begin
        if (rxq.size() == 0) begin
          check("R10 rx unexpected word", {rx_ferr, rx_data}, 10'h3ff);
        end else begin
          re = rxq.pop_front();
          rt = rtag.pop_front();
          check(rt, {rx_ferr, rx_data}, re);
        end
      end
    end
  end

  task automatic send_tx(input logic [8:0] w);
    @(negedge clk);
    while (tx_ready !== 1'b1) @(negedge clk);
    txq.push_back(w);
    tx_data  = w;
    tx_valid = 1'b1;
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic tx_drain();
    while (txq.size() != 0) @(negedge clk);
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic hold_bit(input logic v, input bit glitch);
    rxd = v;
    if (glitch) begin
      repeat (bitclk / 2 - 1) @(posedge clk);
      #1 rxd = ~v;
      repeat (2) @(posedge clk);
      #1 rxd = v;
      repeat (bitclk / 2 - 1) @(posedge clk);
    end else begin
      repeat (bitclk) @(posedge clk);
    end
    #1;
  endtask

  // drive one frame on rxd; glitch_pos is a frame position (0 = start)
  task automatic send_rx(input logic [8:0] d, input bit nn, input bit stop_ok,
                         input bit expect_it, input string tag, input int glitch_pos);
    int n;
    n = nn ? 9 : 8;
    if (expect_it) begin
      rxq.push_back({~stop_ok, (nn ? d : {1'b0, d[7:0]})});
      rtag.push_back(tag);
    end
    hold_bit(1'b0, glitch_pos == 0);
    for (int k = 0; k < n; k++) hold_bit(d[k], glitch_pos == k + 1);
    hold_bit(stop_ok, 1'b0);
    hold_bit(1'b1, 1'b0);
  endtask

  initial begin
    #(3_000_000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 txd idle", txd, 1);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 tx_shift_empty", tx_shift_empty, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_overrun", rx_overrun, 0);

    // R2 / R6: fast mode, divisor 3 -> 64 clocks per bit
    send_tx(9'h055);
    tx_drain();
    check("R2 fast bit length", last_low, 64);
    check("R6 shift-empty low for 10 bits", empty_low, 640);

    // R6: second word accepted while the first shifts
    send_tx(9'h0A3);
    send_tx(9'h00F);
    @(negedge clk);
    check("R6 holding register full", tx_ready, 0);
    check("R6 shifter busy", tx_shift_empty, 0);
    tx_drain();

    // R5: nine-bit transmit
    cfg_tx_nine = 1'b1;
    send_tx(9'h1C6);
    send_tx(9'h05A);
    tx_drain();
    cfg_tx_nine = 1'b0;

    // R3: slow mode, divisor 1 -> 128 clocks per bit
    cfg_divisor = 8'd1; cfg_fast = 1'b0; bitclk = 128;
    send_tx(9'h055);
    tx_drain();
    check("R3 slow bit length", last_low, 128);
    cfg_divisor = 8'd3; cfg_fast = 1'b1; bitclk = 64;
    repeat (10) @(posedge clk);

    // R12: disabled transmitter holds the word
    tx_enable = 1'b0;
    send_tx(9'h03C);
    low_seen = 0;
    repeat (3 * bitclk) @(negedge clk);
    check("R12 line stays high", low_seen, 0);
    check("R12 word held", tx_ready, 0);
    tx_enable = 1'b1;
    tx_drain();

    // R4: receive, eight-bit
    @(posedge clk); #1;
    send_rx(9'h096, 0, 1, 1, "R4 rx word 96", -1);
    send_rx(9'h001, 0, 1, 1, "R4 rx word 01", -1);
    send_rx(9'h0FF, 0, 1, 1, "R4 rx word FF", -1);
    // R5: nine-bit receive and eight-bit masking
    cfg_rx_nine = 1'b1;
    send_rx(9'h1AB, 1, 1, 1, "R5 rx nine-bit 1AB", -1);
    send_rx(9'h0AB, 1, 1, 1, "R5 rx nine-bit 0AB", -1);
    cfg_rx_nine = 1'b0;
    send_rx(9'h1D2, 0, 1, 1, "R5 rx eight-bit top zero", -1);
    // R9: framing error belongs to one word
    send_rx(9'h044, 0, 0, 1, "R9 rx bad stop", -1);
    send_rx(9'h045, 0, 1, 1, "R9 rx next word clean", -1);
    // R7: mid-bit glitches outvoted
    send_rx(9'h000, 0, 1, 1, "R7 rx glitch on zero", 4);
    send_rx(9'h0FF, 0, 1, 1, "R7 rx glitch on one", 6);
    send_rx(9'h0C3, 0, 1, 1, "R7 rx glitch on start", 0);

    // R8: short low pulses are not frames
    rxd = 1'b0; repeat (3) @(posedge clk); #1 rxd = 1'b1;
    repeat (bitclk) @(posedge clk); #1;
    rxd = 1'b0; repeat (bitclk / 4) @(posedge clk); #1 rxd = 1'b1;
    repeat (2 * bitclk) @(negedge clk);
    check("R8 no word from pulses", rx_valid, 0);
    check("R8 scoreboard empty", rxq.size(), 0);

    // R10 / R11: overrun with a stalled consumer
    @(posedge clk); #1 rx_ready = 1'b0;
    send_rx(9'h021, 0, 1, 1, "R11 rx first in order", -1);
    send_rx(9'h022, 0, 1, 1, "R11 rx second in order", -1);
    send_rx(9'h023, 0, 1, 0, "", -1);
    @(negedge clk);
    check("R10 overrun raised", rx_overrun, 1);
    check("R11 head held", rx_data, 9'h021);
    check("R11 valid held", rx_valid, 1);
    @(posedge clk); #1 rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 dropped frame not stored", rx_valid, 0);
    @(posedge clk); #1;
    send_rx(9'h024, 0, 1, 0, "", -1);
    @(negedge clk);
    check("R10 halted receiver ignores frame", rx_valid, 0);
    check("R10 overrun sticky", rx_overrun, 1);
    @(posedge clk); #1 rx_continuous = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 overrun cleared", rx_overrun, 0);
    @(posedge clk); #1 rx_continuous = 1'b1;
    repeat (bitclk) @(posedge clk); #1;
    send_rx(9'h025, 0, 1, 1, "R10 rx after restart", -1);

    repeat (bitclk) @(negedge clk);
    check("R4 tx scoreboard drained", txq.size(), 0);
    check("R11 rx scoreboard drained", rxq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule